// File: doc/BRIEF.md
# Control-Register Port Access Sequencer

This block sits between a simple host request port and the handshaked control-register port of a PHY. The host asks for one 16-bit read or write by raising `req_valid` with the access type, address and write data. The sequencer then breaks the access into phases. Each phase places a value on a shared bus field of a 20-bit command word and raises one capture or action strobe. The phase completes through a four-phase handshake on a single acknowledge line. `req_ready` returns high when the access ends, and `rsp_rdata` and `rsp_err` carry the result.

A write takes three phases: address capture, data capture, then the write action. A read takes two phases: address capture, then the read action, which returns the PHY's read data. Every wait for acknowledge, rising or falling, polls the line once every `POLL_CYC` clock cycles and gives up after `MAX_POLLS` unsuccessful polls. An abort reports an error and leaves the PHY side quiet.

The controller has thirteen named states. `ST_IDLE` accepts a request (IDLE->ADDR_SETUP). For the address phase:

- `ST_ADDR_SETUP` drives the address with no strobe for `HOLD_CYC` cycles (->ADDR_REQ).
- `ST_ADDR_REQ` holds the capture-address strobe until acknowledge is high (->ADDR_REL).
- `ST_ADDR_REL` drops the strobe and waits for acknowledge low. It goes to DATA_SETUP for a write or RD_SETUP for a read.

`ST_DATA_SETUP`/`ST_DATA_REQ`/`ST_DATA_REL` do the same for the data and then lead to WR_SETUP. `ST_WR_SETUP` gives one strobe-free cycle (->WR_REQ), then `ST_WR_REQ` and `ST_WR_REL` follow (->IDLE). `ST_RD_SETUP` clears the bus for one cycle (->RD_REQ), and `ST_RD_REQ` latches read data on acknowledge (->RD_REL). `ST_RD_REL` then returns to IDLE. Any timeout in a REQ or REL state goes straight to IDLE.

Top module: `crport_seq`

## Requirements
- R1: Every access begins by driving the address on command bits 17..2 with all strobes low for `HOLD_CYC` (default 2) cycles. The capture-address strobe (bit 19) then rises with the address unchanged.
- R2: A raised strobe stays high until acknowledge is sampled high, or until a timeout occurs. The strobe then falls with the bus value unchanged, and the next phase starts only after acknowledge is sampled low.
- R3: A write issues, in this order: address capture; data capture, with the data held `HOLD_CYC` cycles before strobe bit 18; and the write strobe (bit 0), with the data on the bus for at least one strobe-free cycle first.
- R4: A read issues address capture, then the read strobe (bit 1) with the bus at zero. It latches `phy_rdata` when acknowledge is seen high and presents that value on `rsp_rdata` once `req_ready` returns.
- R5: Each wait polls acknowledge every `POLL_CYC` cycles, for at most `MAX_POLLS` polls. When acknowledge never arrives, the abort edge comes (`MAX_POLLS`-1)*`POLL_CYC`+1 cycles after the strobe rises, which is 797 cycles with the defaults.
- R6: Command word encoding: bit 0 is write, bit 1 is read, bits 17..2 are the value, bit 18 is capture-data and bit 19 is capture-address. At most one strobe is high at a time.
- R7: On a timeout, `rsp_err` is high for exactly one cycle. In that cycle `rsp_rdata` is zero, all strobes are low and `req_ready` is high.
- R8: `req_ready` is low from the edge that accepts a request until the access ends. A request made while busy is ignored.
- R9: Outputs are registered. After reset, `req_ready`=1, `rsp_err`=0, `rsp_rdata`=0 and `phy_cmd`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken while `req_ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle and able to accept a request |
| rsp_rdata | output | 16 | Read result, zero after a timeout |
| rsp_err | output | 1 | One-cycle timeout indication |
| phy_cmd | output | 20 | Command word: value plus four strobes |
| phy_ack | input | 1 | PHY acknowledge |
| phy_rdata | input | 16 | PHY read data |

## Verification
The bound checker watches the handshake rules on every cycle:

- at most one strobe is high;
- a strobe falls only after acknowledge or on an abort, with the bus unchanged;
- capture strobes rise only after a strobe-free cycle with the same bus value;
- the read strobe sees a zero bus;
- the error pulse lasts one cycle with a quiet PHY side;
- ready stays low while any strobe is up.

The phase order of a write and a read, the exact setup length, the data returned by a read, the exact abort latency, and the fact that a request made while busy is ignored can only be shown by the bench's directed scenarios against its PHY model.

// File: rtl/crp_pkg.sv
package crp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_ADDR_REQ,
        ST_ADDR_REL,
        ST_DATA_SETUP,
        ST_DATA_REQ,
        ST_DATA_REL,
        ST_WR_SETUP,
        ST_WR_REQ,
        ST_WR_REL,
        ST_RD_SETUP,
        ST_RD_REQ,
        ST_RD_REL
    } crp_state_e;

    typedef struct packed {
        logic cap_addr;
        logic cap_data;
        logic rd;
        logic wr;
    } crp_strobe_t;

    // States in which the acknowledge line is polled
    function automatic logic is_wait(crp_state_e st);
        return (st == ST_ADDR_REQ) || (st == ST_ADDR_REL) ||
               (st == ST_DATA_REQ) || (st == ST_DATA_REL) ||
               (st == ST_WR_REQ)   || (st == ST_WR_REL)   ||
               (st == ST_RD_REQ)   || (st == ST_RD_REL);
    endfunction

    // Strobe pattern driven while in a state
    function automatic crp_strobe_t state_strobe(crp_state_e st);
        crp_strobe_t s;
        s          = '0;
        s.cap_addr = (st == ST_ADDR_REQ);
        s.cap_data = (st == ST_DATA_REQ);
        s.wr       = (st == ST_WR_REQ);
        s.rd       = (st == ST_RD_REQ);
        return s;
    endfunction

endpackage

// File: rtl/crp_poll_timer.sv
module crp_poll_timer
    #(
    parameter int unsigned POLL_CYC  = 4,
    parameter int unsigned MAX_POLLS = 200
    )
    (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    output logic poll_now,
    output logic poll_last
    );

    localparam int unsigned TW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int unsigned PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS + 1) : 1;

    logic [TW-1:0] tick_q;
    logic [PW-1:0] polls_q;

    assign poll_now  = active && (tick_q == '0);
    assign poll_last = (polls_q == PW'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick_q  <= '0;
            polls_q <= '0;
        end else if (poll_now) begin
            tick_q <= TW'(POLL_CYC - 1);
            if (!poll_last)
                polls_q <= polls_q + 1'b1;
        end else if (active && (tick_q != '0)) begin
            tick_q <= tick_q - 1'b1;
        end
    end

endmodule

// File: rtl/crp_cmd_pack.sv
module crp_cmd_pack
    import crp_pkg::*;
    #(
    parameter int unsigned DATA_W = 16
    )
    (
    input  logic [DATA_W-1:0] val,
    input  crp_strobe_t       stb,
    output logic [DATA_W+3:0] word
    );

    // strobe positions are fixed relative to the value field
    always_comb begin
        word = {stb.cap_addr, stb.cap_data, val, stb.rd, stb.wr};
    end

endmodule

// File: rtl/crport_seq.sv
module crport_seq
    import crp_pkg::*;
    #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned HOLD_CYC  = 2,
    parameter int unsigned POLL_CYC  = 4,
    parameter int unsigned MAX_POLLS = 200
    )
    (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [DATA_W+3:0] phy_cmd,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata
    );

    localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    crp_state_e        st_q, st_nx;
    logic [DATA_W-1:0] addr_q, wdata_q;
    logic              we_q;
    logic [HW-1:0]     hold_q;
    logic [DATA_W-1:0] val_q, val_nx;
    crp_strobe_t       stb_q, stb_nx;
    logic              ready_q, err_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept, timeout, take_rd;
    logic              poll_now, poll_last, tmr_restart, tmr_active;

    assign accept      = (st_q == ST_IDLE) && req_valid;
    assign tmr_active  = is_wait(st_q);
    assign tmr_restart = (st_nx != st_q) && is_wait(st_nx);

    crp_poll_timer #(
        .POLL_CYC  (POLL_CYC),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (tmr_restart),
        .active    (tmr_active),
        .poll_now  (poll_now),
        .poll_last (poll_last)
    );

    // next-state logic
    always_comb begin
        st_nx   = st_q;
        timeout = 1'b0;
        take_rd = 1'b0;
        unique case (st_q)
            ST_IDLE:       if (req_valid) st_nx = ST_ADDR_SETUP;
            ST_ADDR_SETUP: if (hold_q == '0) st_nx = ST_ADDR_REQ;
            ST_ADDR_REQ: if (poll_now) begin
                if (phy_ack)        st_nx = ST_ADDR_REL;
                else if (poll_last) timeout = 1'b1;
            end
            ST_ADDR_REL: if (poll_now) begin
                if (!phy_ack)       st_nx = we_q ? ST_DATA_SETUP : ST_RD_SETUP;
                else if (poll_last) timeout = 1'b1;
            end
            ST_DATA_SETUP: if (hold_q == '0) st_nx = ST_DATA_REQ;
            ST_DATA_REQ: if (poll_now) begin
                if (phy_ack)        st_nx = ST_DATA_REL;
                else if (poll_last) timeout = 1'b1;
            end
            ST_DATA_REL: if (poll_now) begin
                if (!phy_ack)       st_nx = ST_WR_SETUP;
                else if (poll_last) timeout = 1'b1;
            end
            ST_WR_SETUP:   st_nx = ST_WR_REQ;
            ST_WR_REQ: if (poll_now) begin
                if (phy_ack)        st_nx = ST_WR_REL;
                else if (poll_last) timeout = 1'b1;
            end
            ST_WR_REL: if (poll_now) begin
                if (!phy_ack)       st_nx = ST_IDLE;
                else if (poll_last) timeout = 1'b1;
            end
            ST_RD_SETUP:   st_nx = ST_RD_REQ;
            ST_RD_REQ: if (poll_now) begin
                if (phy_ack) begin
                    st_nx   = ST_RD_REL;
                    take_rd = 1'b1;
                end else if (poll_last) begin
                    timeout = 1'b1;
                end
            end
            ST_RD_REL: if (poll_now) begin
                if (!phy_ack)       st_nx = ST_IDLE;
                else if (poll_last) timeout = 1'b1;
            end
            default:       st_nx = ST_IDLE;
        endcase
        if (timeout)
            st_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // request capture and setup hold counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            hold_q  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                we_q    <= req_we;
            end
            if ((st_nx != st_q) &&
                ((st_nx == ST_ADDR_SETUP) || (st_nx == ST_DATA_SETUP)))
                hold_q <= HW'(HOLD_CYC - 1);
            else if (hold_q != '0)
                hold_q <= hold_q - 1'b1;
        end
    end

    // bus value and strobes for the coming state
    always_comb begin
        unique case (st_nx)
            ST_ADDR_SETUP, ST_ADDR_REQ, ST_ADDR_REL:
                val_nx = accept ? req_addr : addr_q;
            ST_DATA_SETUP, ST_DATA_REQ, ST_DATA_REL,
            ST_WR_SETUP, ST_WR_REQ, ST_WR_REL:
                val_nx = wdata_q;
            default:
                val_nx = '0;
        endcase
        stb_nx = state_strobe(st_nx);
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q   <= '0;
            stb_q   <= '0;
            ready_q <= 1'b1;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            val_q   <= val_nx;
            stb_q   <= stb_nx;
            ready_q <= (st_nx == ST_IDLE);
            err_q   <= timeout;
            if (accept || timeout) rdata_q <= '0;
            else if (take_rd)      rdata_q <= phy_rdata;
        end
    end

    crp_cmd_pack #(.DATA_W(DATA_W)) u_pack (
        .val  (val_q),
        .stb  (stb_q),
        .word (phy_cmd)
    );

    assign req_ready = ready_q;
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/crport_seq_chk.sv
module crport_seq_chk
    #(
    parameter int unsigned DATA_W = 16
    )
    (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic [DATA_W+3:0] phy_cmd,
    input logic              phy_ack
    );

    logic              s_wr, s_rd, s_cd, s_ca, s_any;
    logic [DATA_W-1:0] bus;

    assign s_wr  = phy_cmd[0];
    assign s_rd  = phy_cmd[1];
    assign s_cd  = phy_cmd[DATA_W+2];
    assign s_ca  = phy_cmd[DATA_W+3];
    assign bus   = phy_cmd[DATA_W+1:2];
    assign s_any = s_wr | s_rd | s_cd | s_ca;

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_ca, s_cd, s_rd, s_wr}));

    // R2
    drop_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_any) |-> ($past(phy_ack) || rsp_err));

    // R2
    drop_bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_any) && !rsp_err) |-> $stable(bus));

    // R1
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_ca) |-> ($stable(bus) && $past(!s_any)));

    // R3
    data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_cd) || $rose(s_wr)) |-> ($stable(bus) && $past(!s_any)));

    // R4
    rd_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rd |-> (bus == '0));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !rsp_err);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (req_ready && !s_any && (rsp_rdata == '0)));

    // R8
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_any |-> !req_ready);

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

endmodule

bind crport_seq crport_seq_chk #(.DATA_W(DATA_W)) i_crport_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .phy_cmd   (phy_cmd),
    .phy_ack   (phy_ack)
);

// File: tb/test_crport_seq.sv
`timescale 1ns/1ps
module test_crport_seq;

    localparam int HOLD  = 2;
    localparam int POLL  = 4;
    localparam int MAXP  = 200;
    localparam int TO_LAT = (MAXP - 1) * POLL + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic [19:0] phy_cmd;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    crport_seq #(
        .DATA_W(16), .HOLD_CYC(HOLD), .POLL_CYC(POLL), .MAX_POLLS(MAXP)
    ) i_crport_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .phy_cmd(phy_cmd),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    // ---------------- PHY model and monitor ----------------
    int          cyc = 0;
    int          ack_lat = 2;
    logic        mute_hi = 1'b0;
    logic        stuck_hi = 1'b0;
    int          wait_cnt = 0;
    logic [15:0] m_addr = '0;
    logic [15:0] m_data = '0;
    logic [15:0] mem [16];

    int          log_n = 0;
    int          log_kind [8];
    int          log_val [8];
    int          log_word [8];
    int          log_stab [8];
    int          log_t [8];
    logic        prev_stb = 1'b0;
    logic [15:0] prev_v = '0;
    int          stable = 0;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h1000 + 16'(i);
    end

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        logic stb;
        stb = phy_cmd[19] | phy_cmd[18] | phy_cmd[1] | phy_cmd[0];
        if (stb && !phy_ack) begin
            if (!mute_hi) begin
                if (wait_cnt >= ack_lat) begin
                    wait_cnt = 0;
                    if (phy_cmd[19]) m_addr = phy_cmd[17:2];
                    if (phy_cmd[18]) m_data = phy_cmd[17:2];
                    if (phy_cmd[0])  mem[m_addr[3:0]] = m_data;
                    if (phy_cmd[1])  phy_rdata = mem[m_addr[3:0]];
                    phy_ack = 1'b1;
                end else begin
                    wait_cnt = wait_cnt + 1;
                end
            end
        end else if (!stb && phy_ack) begin
            if (!stuck_hi) begin
                if (wait_cnt >= ack_lat) begin
                    wait_cnt = 0;
                    phy_ack  = 1'b0;
                end else begin
                    wait_cnt = wait_cnt + 1;
                end
            end
        end else begin
            wait_cnt = 0;
        end
    end

    always @(negedge clk) begin
        logic        stb;
        logic [15:0] v;
        stb = phy_cmd[19] | phy_cmd[18] | phy_cmd[1] | phy_cmd[0];
        v   = phy_cmd[17:2];
        if (stb && !prev_stb && log_n < 8) begin
            log_kind[log_n] = phy_cmd[19] ? 0 : phy_cmd[18] ? 1 : phy_cmd[0] ? 2 : 3;
            log_val[log_n]  = int'(v);
            log_word[log_n] = int'(phy_cmd);
            log_stab[log_n] = stable;
            log_t[log_n]    = cyc;
            log_n = log_n + 1;
        end
        if (stb)                          stable = 0;
        else if (v == prev_v && stable > 0) stable = stable + 1;
        else                              stable = 1;
        prev_stb = stb;
        prev_v   = v;
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int   end_t;
    logic end_err;

    task automatic run_req(input logic we, input logic [15:0] a, input logic [15:0] d);
        int n;
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 ready low after accept", int'(req_ready), 0);
        n = 0;
        while (!req_ready && n < 5000) begin
            @(negedge clk);
            n = n + 1;
        end
        chk(req_ready, "R8 access finished", int'(req_ready), 1);
        end_t   = cyc;
        end_err = rsp_err;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
        chk(rsp_err == 1'b0, "R9 reset err", int'(rsp_err), 0);
        chk(rsp_rdata == 16'h0, "R9 reset rdata", int'(rsp_rdata), 0);
        chk(phy_cmd == 20'h0, "R9 reset cmd", int'(phy_cmd), 0);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [15:0] d);
        run_req(1'b1, a, d);
        chk(end_err == 1'b0, "R3 write no error", int'(end_err), 0);
        chk(log_n == 3, "R3 write phase count", log_n, 3);
        chk(log_kind[0] == 0 && log_kind[1] == 1 && log_kind[2] == 2, "R3 write order",
            log_kind[0] * 16 + log_kind[1] * 4 + log_kind[2], 6);
        chk(log_word[0] == (32'h80000 | (int'(a) << 2)), "R1 R6 addr word",
            log_word[0], 32'h80000 | (int'(a) << 2));
        chk(log_stab[0] >= HOLD, "R1 addr setup cycles", log_stab[0], HOLD);
        chk(log_word[1] == (32'h40000 | (int'(d) << 2)), "R3 R6 data word",
            log_word[1], 32'h40000 | (int'(d) << 2));
        chk(log_stab[1] >= HOLD, "R3 data setup cycles", log_stab[1], HOLD);
        chk(log_word[2] == ((int'(d) << 2) | 1), "R3 R6 write word",
            log_word[2], (int'(d) << 2) | 1);
        chk(log_stab[2] >= 1, "R3 write setup cycles", log_stab[2], 1);
        chk(mem[a[3:0]] == d, "R2 write reached PHY", int'(mem[a[3:0]]), int'(d));
    endtask

    task automatic t_read(input logic [15:0] a, input logic [15:0] exp);
        run_req(1'b0, a, 16'hFFFF);
        chk(end_err == 1'b0, "R4 read no error", int'(end_err), 0);
        chk(log_n == 2, "R4 read phase count", log_n, 2);
        chk(log_kind[0] == 0 && log_kind[1] == 3, "R4 read order",
            log_kind[0] * 4 + log_kind[1], 3);
        chk(log_word[1] == 2, "R4 R6 read word with zero bus", log_word[1], 2);
        chk(rsp_rdata == exp, "R4 read data", int'(rsp_rdata), int'(exp));
    endtask

    task automatic t_timeout_mute();
        mute_hi = 1'b1;
        run_req(1'b0, 16'h0003, 16'h0);
        chk(end_err == 1'b1, "R5 timeout flagged", int'(end_err), 1);
        chk(log_n == 1, "R5 aborted after address strobe", log_n, 1);
        chk(end_t - log_t[0] == TO_LAT, "R5 timeout latency", end_t - log_t[0], TO_LAT);
        chk(rsp_rdata == 16'h0, "R7 rdata zero on timeout", int'(rsp_rdata), 0);
        chk(phy_cmd == 20'h0, "R7 strobes low on timeout", int'(phy_cmd), 0);
        @(negedge clk);
        chk(rsp_err == 1'b0, "R7 error lasts one cycle", int'(rsp_err), 0);
        mute_hi = 1'b0;
    endtask

    task automatic t_timeout_stuck();
        stuck_hi = 1'b1;
        run_req(1'b1, 16'h0009, 16'h7777);
        chk(end_err == 1'b1, "R2 R5 release wait times out", int'(end_err), 1);
        chk(log_n == 1, "R2 no next phase while ack high", log_n, 1);
        chk(mem[9] == 16'h1009, "R2 stuck write not applied", int'(mem[9]), 16'h1009);
        @(negedge clk);
        chk(rsp_err == 1'b0, "R7 error lasts one cycle (release)", int'(rsp_err), 0);
        stuck_hi = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int n;
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h0005; req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h0006; req_wdata = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!req_ready && n < 5000) begin
            @(negedge clk);
            n = n + 1;
        end
        chk(log_n == 3, "R8 busy request added no phases", log_n, 3);
        chk(log_val[0] == 5, "R8 original address kept", log_val[0], 5);
        chk(log_val[2] == 16'hBEEF, "R8 original data kept", log_val[2], 16'hBEEF);
        repeat (3) @(negedge clk);
        chk(log_n == 3, "R8 busy request not started later", log_n, 3);
        t_read(16'h0006, 16'h1006);
    endtask

    task automatic t_slow_ack();
        ack_lat = 100;
        t_write(16'h000C, 16'h5A5A);
        t_read(16'h000C, 16'h5A5A);
        ack_lat = 2;
    endtask

    // ---------------- main ----------------
    logic done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write(16'h0002, 16'hA5A5);
        t_read(16'h0002, 16'hA5A5);
        t_write(16'h000F, 16'hFFFF);
        t_read(16'h000F, 16'hFFFF);
        t_read(16'h0004, 16'h1004);
        t_busy_ignore();
        t_timeout_mute();
        t_timeout_stuck();
        t_slow_ack();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(64'd8 * 64'd200000);
        if (!done) begin
            n_chk = n_chk + 1;
            n_err = n_err + 1;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule